// File: doc/BRIEF.md
# Latchable Bidirectional Parity Transceiver

This block carries a data word and its parity bit between two ports, A and B, in either direction. Each port has its own storage stage. When that stage's enable is high it is transparent. When the enable is low it holds the word captured at the last clock edge on which the enable was high. The port on the far side is driven from that stored word. In generate mode the parity bit sent out is recomputed from the data. In feed-through mode the received parity bit is passed on unchanged. A sense input chooses even or odd parity for both sides.

Each side also checks the stored word against its own parity bit. It reports a mismatch on an active-low error pin, whether or not any output is enabled. The bidirectional pads are split into input, output and output-valid ports. Each output is gated by an active-low enable. A disabled port reads as all zeros with its valid flag low.

The block is a transceiver and cannot stall, so there is no ready input. The valid flag on each output only reflects its enable. The destination must accept the word in the cycle in which it is driven, and back-pressure has to be applied upstream of the latch enables.

Top module: `pxc_xcvr`

## Requirements
- R1: After reset both stored words are zero. With both latch enables low, an enabled output shows data 0, and its parity equals the sense bit in generate mode.
- R2: With a side's latch enable high, the opposite enabled output carries that side's input data in the same cycle, with no clock edge needed.
- R3: With a side's latch enable low, the opposite output keeps the data and parity captured at the last rising clock edge on which that enable was high, whatever that side's inputs do.
- R4: In generate mode (mode input 0), the outgoing parity bit is chosen so that the outgoing data plus parity obey the selected parity sense.
- R5: In feed-through mode (mode input 1), the outgoing parity bit equals the stored received parity bit, even when that bit is wrong.
- R6: Sense input 0 selects even parity: the data plus parity hold an even count of ones. Sense input 1 selects odd parity: they hold an odd count.
- R7: Each side's error output is 0 exactly when its stored data plus stored parity bit break the selected parity sense. This holds in both modes and whatever the output enables are.
- R8: Output enables are active low. When a port's enable is 1, its valid flag is 0 and its data and parity outputs are 0. When the enable is 0, the valid flag is 1.
- R9: Transfer from B to A obeys R2 to R5 exactly as transfer from A to B does.
- R10: The two latch enables act independently. One side can hold while the other stays transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the storage stages |
| rst_n | input | 1 | Asynchronous active-low reset; clears the stored words |
| a_data_i | input | DW | Data arriving on port A |
| a_par_i | input | 1 | Parity bit arriving on port A |
| b_data_i | input | DW | Data arriving on port B |
| b_par_i | input | 1 | Parity bit arriving on port B |
| odd_sel_i | input | 1 | Parity sense: 0 even, 1 odd |
| feed_sel_i | input | 1 | Mode: 0 generate, 1 feed-through |
| a_le_i | input | 1 | Side A storage enable, 1 transparent |
| b_le_i | input | 1 | Side B storage enable, 1 transparent |
| a_oe_n_i | input | 1 | Active-low enable for driving port A |
| b_oe_n_i | input | 1 | Active-low enable for driving port B |
| a_data_o | output | DW | Data driven onto port A (from side B) |
| a_par_o | output | 1 | Parity driven onto port A |
| a_valid_o | output | 1 | Port A output is being driven |
| b_data_o | output | DW | Data driven onto port B (from side A) |
| b_par_o | output | 1 | Parity driven onto port B |
| b_valid_o | output | 1 | Port B output is being driven |
| a_err_n_o | output | 1 | Side A parity error, active low |
| b_err_n_o | output | 1 | Side B parity error, active low |

## Verification
The properties assume that every control and data input changes only between clock edges. That assumption is what lets a hold property compare an output with its value one edge earlier. The stimulus makes all its changes on the falling edge. The properties also assume that the two output enables are never active together, since that state is illegal on a shared pair of buses. The stimulus enables at most one port at a time during the sweeps. During the hold and independence tests, where both outputs are checked, it enables each port in turn.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic {PAR_EVEN = 1'b0, PAR_ODD = 1'b1} par_sense_e;
  typedef enum logic {MODE_GEN = 1'b0, MODE_FEED = 1'b1} par_mode_e;
  localparam int SIDES = 2;
endpackage

// File: rtl/pxc_latch.sv
module pxc_latch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held <= '0;
    else if (le) held <= d;
  end

  // transparent path bypasses the register while enabled
  assign q = le ? d : held;
endmodule

// File: rtl/pxc_parity.sv
module pxc_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic         sense,
  input  logic         par_in,
  output logic         par_gen,
  output logic         err_n
);
  // bit that makes data plus parity match the chosen sense
  assign par_gen = (^data) ^ sense;
  assign err_n   = (par_gen == par_in);
endmodule

// File: rtl/pxc_drive.sv
module pxc_drive #(
  parameter int W = 8
) (
  input  logic                 oe_n,
  input  pxc_pkg::par_mode_e   mode,
  input  logic [W-1:0]         data,
  input  logic                 par_held,
  input  logic                 par_gen,
  output logic [W-1:0]         out_data,
  output logic                 out_par,
  output logic                 out_valid
);
  import pxc_pkg::*;

  always_comb begin
    out_valid = !oe_n;
    out_data  = '0;
    out_par   = 1'b0;
    if (!oe_n) begin
      out_data = data;
      out_par  = (mode == MODE_FEED) ? par_held : par_gen;
    end
  end
endmodule

// File: rtl/pxc_xcvr.sv
module pxc_xcvr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] a_data_i,
  input  logic          a_par_i,
  input  logic [DW-1:0] b_data_i,
  input  logic          b_par_i,
  input  logic          odd_sel_i,
  input  logic          feed_sel_i,
  input  logic          a_le_i,
  input  logic          b_le_i,
  input  logic          a_oe_n_i,
  input  logic          b_oe_n_i,
  output logic [DW-1:0] a_data_o,
  output logic          a_par_o,
  output logic          a_valid_o,
  output logic [DW-1:0] b_data_o,
  output logic          b_par_o,
  output logic          b_valid_o,
  output logic          a_err_n_o,
  output logic          b_err_n_o
);
  import pxc_pkg::*;

  localparam int WW = DW + 1;  // stored word: parity on top of data

  logic [SIDES-1:0][WW-1:0] word_in;
  logic [SIDES-1:0][WW-1:0] word_q;
  logic [SIDES-1:0]         le;
  logic [SIDES-1:0]         oe_n;
  logic [SIDES-1:0]         par_gen;
  logic [SIDES-1:0]         err_n;
  logic [SIDES-1:0][DW-1:0] out_data;
  logic [SIDES-1:0]         out_par;
  logic [SIDES-1:0]         out_valid;
  par_mode_e                mode;

  assign mode       = par_mode_e'(feed_sel_i);
  assign word_in[0] = {a_par_i, a_data_i};
  assign word_in[1] = {b_par_i, b_data_i};
  assign le         = {b_le_i, a_le_i};
  assign oe_n       = {b_oe_n_i, a_oe_n_i};

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    pxc_latch #(.W(WW)) u_latch (
      .clk (clk),
      .rst_n (rst_n),
      .le  (le[g]),
      .d   (word_in[g]),
      .q   (word_q[g])
    );

    pxc_parity #(.W(DW)) u_par (
      .data    (word_q[g][DW-1:0]),
      .sense   (odd_sel_i),
      .par_in  (word_q[g][DW]),
      .par_gen (par_gen[g]),
      .err_n   (err_n[g])
    );

    // side g's stored word drives the port on the opposite side
    pxc_drive #(.W(DW)) u_drv (
      .oe_n      (oe_n[SIDES-1-g]),
      .mode      (mode),
      .data      (word_q[g][DW-1:0]),
      .par_held  (word_q[g][DW]),
      .par_gen   (par_gen[g]),
      .out_data  (out_data[SIDES-1-g]),
      .out_par   (out_par[SIDES-1-g]),
      .out_valid (out_valid[SIDES-1-g])
    );
  end

  assign a_data_o  = out_data[0];
  assign a_par_o   = out_par[0];
  assign a_valid_o = out_valid[0];
  assign b_data_o  = out_data[1];
  assign b_par_o   = out_par[1];
  assign b_valid_o = out_valid[1];
  assign a_err_n_o = err_n[0];
  assign b_err_n_o = err_n[1];
endmodule

// File: rtl/pxc_xcvr_chk.sv
module pxc_xcvr_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] a_data_i,
  input logic          a_par_i,
  input logic [DW-1:0] b_data_i,
  input logic          b_par_i,
  input logic          odd_sel_i,
  input logic          feed_sel_i,
  input logic          a_le_i,
  input logic          b_le_i,
  input logic          a_oe_n_i,
  input logic          b_oe_n_i,
  input logic [DW-1:0] a_data_o,
  input logic          a_par_o,
  input logic          a_valid_o,
  input logic [DW-1:0] b_data_o,
  input logic          b_par_o,
  input logic          b_valid_o,
  input logic          a_err_n_o,
  input logic          b_err_n_o
);
  AST_B_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    b_oe_n_i |-> (!b_valid_o && b_data_o == '0 && !b_par_o)); // R8
  AST_A_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe_n_i |-> (!a_valid_o && a_data_o == '0 && !a_par_o)); // R8
  AST_B_GEN_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_oe_n_i && !feed_sel_i) |-> ((^{b_data_o, b_par_o}) == odd_sel_i)); // R4
  AST_A_GEN_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_oe_n_i && !feed_sel_i) |-> ((^{a_data_o, a_par_o}) == odd_sel_i)); // R9
  AST_B_FEED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_oe_n_i && feed_sel_i && a_le_i) |-> (b_data_o == a_data_i && b_par_o == a_par_i)); // R5
  AST_A_FLOW_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_oe_n_i && b_le_i) |-> (a_data_o == b_data_i)); // R2
  AST_A_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    a_le_i |-> (a_err_n_o == ((^{a_data_i, a_par_i}) == odd_sel_i))); // R7
  AST_B_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    b_le_i |-> (b_err_n_o == ((^{b_data_i, b_par_i}) == odd_sel_i))); // R7
  AST_A_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_le_i && $past(!a_le_i) && !b_oe_n_i && $past(!b_oe_n_i)) |-> $stable(b_data_o)); // R3
  AST_B_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_le_i && $past(!b_le_i) && !a_oe_n_i && $past(!a_oe_n_i)) |-> $stable(a_data_o)); // R10
endmodule

bind pxc_xcvr pxc_xcvr_chk #(.DW(DW)) u_chk (.*);

// File: tb/pxc_xcvr_tb.sv
module pxc_xcvr_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] a_data_i = '0, b_data_i = '0;
  logic          a_par_i = 1'b0, b_par_i = 1'b0;
  logic          odd_sel_i = 1'b0, feed_sel_i = 1'b0;
  logic          a_le_i = 1'b0, b_le_i = 1'b0;
  logic          a_oe_n_i = 1'b1, b_oe_n_i = 1'b0;
  logic [DW-1:0] a_data_o, b_data_o;
  logic          a_par_o, b_par_o, a_valid_o, b_valid_o, a_err_n_o, b_err_n_o;

  int nvec = 0;
  int nerr = 0;

  pxc_xcvr #(.DW(DW)) u_dut (.*);

  always #10 clk = ~clk;

  function automatic int ones(input logic [DW-1:0] d);
    int n = 0;
    for (int i = 0; i < DW; i++) n += d[i];
    return n;
  endfunction

  // parity bit that completes the word for the given sense
  function automatic logic gen_par(input logic [DW-1:0] d, input logic odd);
    return logic'((ones(d) + (odd ? 1 : 0)) % 2);
  endfunction

  function automatic logic exp_errn(input logic [DW-1:0] d, input logic p, input logic odd);
    return logic'(((ones(d) + p) % 2) == (odd ? 1 : 0));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1: cleared storage, both enables low
    chk("R1", "b_data", b_data_o, 0);
    chk("R1", "b_par even", b_par_o, 0);
    chk("R8", "b_valid on", b_valid_o, 1);
    chk("R8", "a_valid off", a_valid_o, 0);
    chk("R7", "a_err_n clear", a_err_n_o, 1);
    odd_sel_i = 1'b1; #2;
    chk("R1", "b_par odd", b_par_o, 1);
    chk("R7", "a_err_n odd on zero word", a_err_n_o, 0);

    // R2 R4 R5 R6 R7 R8: A to B sweep, A transparent
    a_le_i = 1'b1; b_le_i = 1'b0; a_oe_n_i = 1'b1; b_oe_n_i = 1'b0;
    for (int v = 0; v < 2048; v++) begin
      @(negedge clk);
      a_data_i = v[7:0]; a_par_i = v[8]; odd_sel_i = v[9]; feed_sel_i = v[10];
      #2;
      chk("R2", "b_data", b_data_o, v[7:0]);
      chk(v[10] ? "R5" : "R4", "b_par", b_par_o, v[10] ? v[8] : gen_par(v[7:0], v[9]));
      chk("R7", "a_err_n", a_err_n_o, exp_errn(v[7:0], v[8], v[9]));
      chk("R8", "a_data off", a_data_o, 0);
    end

    // R9: B to A sweep, B transparent
    a_le_i = 1'b0; b_le_i = 1'b1; a_oe_n_i = 1'b0; b_oe_n_i = 1'b1;
    for (int v = 0; v < 2048; v++) begin
      @(negedge clk);
      b_data_i = v[7:0]; b_par_i = v[8]; odd_sel_i = v[9]; feed_sel_i = v[10];
      #2;
      chk("R9", "a_data", a_data_o, v[7:0]);
      chk("R9", "a_par", a_par_o, v[10] ? v[8] : gen_par(v[7:0], v[9]));
      chk("R7", "b_err_n", b_err_n_o, exp_errn(v[7:0], v[8], v[9]));
      chk("R8", "b_par off", b_par_o, 0);
    end

    // R3 R10: A holds while B stays transparent
    @(negedge clk);
    a_le_i = 1'b1; b_le_i = 1'b1; feed_sel_i = 1'b1; odd_sel_i = 1'b0;
    a_data_i = 8'h5A; a_par_i = 1'b1; b_data_i = 8'hC3; b_par_i = 1'b0;
    a_oe_n_i = 1'b1; b_oe_n_i = 1'b0;
    @(negedge clk);
    a_le_i = 1'b0; a_data_i = 8'h11; a_par_i = 1'b0; b_data_i = 8'h07;
    repeat (3) @(negedge clk);
    #2;
    chk("R3", "b_data held", b_data_o, 8'h5A);
    chk("R3", "b_par held", b_par_o, 1);
    chk("R7", "a_err_n from held", a_err_n_o, exp_errn(8'h5A, 1'b1, 1'b0));
    a_oe_n_i = 1'b0; b_oe_n_i = 1'b1; #2;
    chk("R10", "a_data transparent", a_data_o, 8'h07);
    chk("R8", "b_valid off", b_valid_o, 0);
    chk("R7", "a_err_n with oe off", a_err_n_o, exp_errn(8'h5A, 1'b1, 1'b0));

    // R10: B holds while A stays transparent
    @(negedge clk);
    b_le_i = 1'b0; b_data_i = 8'hFF; b_par_i = 1'b1;
    a_le_i = 1'b1; a_data_i = 8'h3C; a_par_i = 1'b1;
    @(negedge clk); #2;
    chk("R10", "a_data held", a_data_o, 8'h07);
    chk("R7", "b_err_n held", b_err_n_o, exp_errn(8'h07, 1'b0, 1'b0));
    a_oe_n_i = 1'b1; b_oe_n_i = 1'b0; feed_sel_i = 1'b0; odd_sel_i = 1'b1; #2;
    chk("R10", "b_data transparent", b_data_o, 8'h3C);
    chk("R6", "b_par odd gen", b_par_o, gen_par(8'h3C, 1'b1));
    chk("R3", "a_data off while held", a_data_o, 0);

    finish_run();
  end
endmodule